// File: doc/BRIEF.md
# Sector Track Assembler and Best-Three Selector

This block takes the pairwise link qualities found between stub pairs in one detector sector and turns them into track candidates. The sector holds four measuring stations. Station 1 offers six stub slots, and stations 2, 3 and 4 offer three slots each. A link joins one stub in one station to one stub in another, and carries a small quality code. Links that share the stub of their common station are chained into tracks that span two, three or four stations.

A short track is removed when a longer track of three or four stations contains all of its stubs. The block then ranks the surviving tracks. It picks up to three of them, and no two picks may use the same stub.

Each pick is reported as a valid flag, a station-presence mask and one stub index per station. Index 0 means that the station has no stub in the track. The block is fully pipelined: it accepts a new sector every clock cycle and gives each result after a fixed delay.

Top module: `sp_track_select`

## Requirements
- R1: `out_valid` rises on the third rising edge counting the edge that samples `in_valid` high, so it lags `in_valid` by exactly three cycles. Inputs may be presented on consecutive cycles, and each one gives its own result.
- R2: Each link port packs 2-bit quality codes. The code for stub a of the lower station and stub b of the higher station (both counted from 1) sits at bit offset ((a-1)*3+(b-1))*2. Code 0 means no link.
- R3: A two-station track exists for every nonzero link. A candidate always spans at least two stations. Station s maps to mask bit s-1. A stub index is 1 to 6 in station 1, 1 to 3 elsewhere, and 0 when the station is absent.
- R4: A track of three or four stations exists only when every pair of stations that are adjacent in station order within the track has a nonzero link, and the shared stub index is the same in every link. The possible forms are 1-2-3, 1-2-4, 1-3-4, 2-3-4 and 1-2-3-4.
- R5: A track is cancelled, and is never reported, when a valid track with more stations (at least three) uses every one of its stubs. This holds even if that longer track is itself not picked.
- R6: Candidates are ranked first by station count and then by the sum of the qualities of the links they chain.
- R7: Among candidates of equal rank, the lower station-1 index wins, then the lower index in station 2, then in station 3, then in station 4.
- R8: No two reported candidates share a stub in any station. A lower-ranked track that reuses a stub already taken is skipped.
- R9: Slot 0 holds the best candidate, and the slots are filled in rank order without gaps. An unused slot shows a clear valid bit, a zero mask and zero indices.
- R10: While reset is active, and after it ends, `out_valid` and all candidate fields are zero until a result arrives.
- R11: In a cycle where `out_valid` is low, every candidate field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| in_valid | input | 1 | The link ports carry one sector this cycle |
| lq12 | input | 36 | Links from station 1 to station 2 |
| lq13 | input | 36 | Links from station 1 to station 3 |
| lq14 | input | 36 | Links from station 1 to station 4 |
| lq23 | input | 18 | Links from station 2 to station 3 |
| lq24 | input | 18 | Links from station 2 to station 4 |
| lq34 | input | 18 | Links from station 3 to station 4 |
| out_valid | output | 1 | A result is present |
| cand_vld | output | 3 | Per-slot candidate valid |
| cand_mask | output | 12 | Per-slot 4-bit station mask, slot r at bits [4r+3:4r] |
| cand_s1 | output | 9 | Per-slot station-1 stub index, 3 bits each |
| cand_s2 | output | 6 | Per-slot station-2 stub index, 2 bits each |
| cand_s3 | output | 6 | Per-slot station-3 stub index, 2 bits each |
| cand_s4 | output | 6 | Per-slot station-4 stub index, 2 bits each |

## Verification
The bench builds the block with its default sizing: six station-1 slots, three slots in each later station, 2-bit qualities and three output slots. With these values every one of the 448 index combinations can be reached, including index 6 in station 1 and index 3 elsewhere. The 2-bit qualities make ties in the quality sum common, which exercises the index tie-break. Three output slots are enough to build cases where a cancelled subset would otherwise fill a slot that a stub conflict has left empty.

// File: rtl/sp_trk_pkg.sv
package sp_trk_pkg;

  // Stub index of station s (0..3) within combination code c; nb is the
  // radix of stations 2..4 (slots + 1). Station 1 is the most significant.
  function automatic int stub_at(input int c, input int s, input int nb);
    case (s)
      0:       return c / (nb * nb * nb);
      1:       return (c / (nb * nb)) % nb;
      2:       return (c / nb) % nb;
      default: return c % nb;
    endcase
  endfunction

  // Combination-code weight of station s.
  function automatic int weight_of(input int s, input int nb);
    case (s)
      0:       return nb * nb * nb;
      1:       return nb * nb;
      2:       return nb;
      default: return 1;
    endcase
  endfunction

  // Number of stations present in combination c.
  function automatic int span_of(input int c, input int nb);
    int n;
    n = 0;
    for (int s = 0; s < 4; s++)
      if (stub_at(c, s, nb) != 0) n++;
    return n;
  endfunction

  // Link-port number for stations sa < sb (0..3).
  function automatic int pair_of(input int sa, input int sb);
    if (sa == 0) return sb - 1;
    if (sa == 1) return sb + 1;
    return 5;
  endfunction

endpackage

// File: rtl/sp_link_capture.sv
module sp_link_capture #(
  parameter int N1 = 6,
  parameter int NS = 3,
  parameter int QW = 2,
  localparam int W1 = N1 * NS * QW,
  localparam int W2 = NS * NS * QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W1-1:0] lq12,
  input  logic [W1-1:0] lq13,
  input  logic [W1-1:0] lq14,
  input  logic [W2-1:0] lq23,
  input  logic [W2-1:0] lq24,
  input  logic [W2-1:0] lq34,
  output logic          v_q,
  output logic [W1-1:0] lnk_q [6]
);

  logic [W1-1:0] lnk_d [6];
  logic          cap_en;

  assign cap_en = in_valid;

  always_comb begin
    lnk_d[0] = lq12;
    lnk_d[1] = lq13;
    lnk_d[2] = lq14;
    lnk_d[3] = {{(W1-W2){1'b0}}, lq23};
    lnk_d[4] = {{(W1-W2){1'b0}}, lq24};
    lnk_d[5] = {{(W1-W2){1'b0}}, lq34};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      for (int p = 0; p < 6; p++) lnk_q[p] <= '0;
    end else begin
      v_q <= in_valid;
      if (cap_en)
        for (int p = 0; p < 6; p++) lnk_q[p] <= lnk_d[p];
    end
  end

endmodule

// File: rtl/sp_track_builder.sv
module sp_track_builder
  import sp_trk_pkg::*;
#(
  parameter int N1 = 6,
  parameter int NS = 3,
  parameter int QW = 2,
  localparam int W1 = N1 * NS * QW,
  localparam int NB = NS + 1,
  localparam int NC = (N1 + 1) * NB * NB * NB,
  localparam int SW = QW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [W1-1:0] lnk [6],
  output logic          v_q,
  output logic [NC-1:0] alive_q,
  output logic [SW-1:0] qsum_q [NC]
);

  logic [NC-1:0] valid_c;
  logic [NC-1:0] long_c;
  logic [NC-1:0] up_c;
  logic [NC-1:0] cov_c;
  logic [SW-1:0] sum_c [NC];
  logic          upd_en;

  assign upd_en = v_in;

  // Chain validity and quality sum for every stub combination.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      int prev;
      int nsta;
      int acc;
      logic ok;
      logic [QW-1:0] q;
      prev = -1;
      nsta = 0;
      acc  = 0;
      ok   = 1'b1;
      q    = '0;
      for (int s = 0; s < 4; s++) begin
        if (stub_at(c, s, NB) != 0) begin
          if (prev >= 0) begin
            q = lnk[pair_of(prev, s)][((stub_at(c, prev, NB) - 1) * NS
                                       + (stub_at(c, s, NB) - 1)) * QW +: QW];
            if (q == '0) ok = 1'b0;
            acc = acc + int'(q);
          end
          prev = s;
          nsta = nsta + 1;
        end
      end
      valid_c[c] = ok && (nsta >= 2);
      long_c[c]  = ok && (nsta >= 3);
      sum_c[c]   = SW'(acc);
    end
  end

  // up: combination is itself a long track, or one station added makes one.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      up_c[c] = long_c[c];
      for (int s = 0; s < 4; s++)
        if (stub_at(c, s, NB) == 0)
          for (int k = 1; k <= ((s == 0) ? N1 : NS); k++)
            if (long_c[c + k * weight_of(s, NB)]) up_c[c] = 1'b1;
    end
  end

  // covered: some strict superset is a long track.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cov_c[c] = 1'b0;
      if (span_of(c, NB) < 4)
        for (int s = 0; s < 4; s++)
          if (stub_at(c, s, NB) == 0)
            for (int k = 1; k <= ((s == 0) ? N1 : NS); k++)
              if (up_c[c + k * weight_of(s, NB)]) cov_c[c] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      alive_q <= '0;
      for (int c = 0; c < NC; c++) qsum_q[c] <= '0;
    end else begin
      v_q <= v_in;
      if (upd_en) begin
        alive_q <= valid_c & ~cov_c;
        for (int c = 0; c < NC; c++) qsum_q[c] <= sum_c[c];
      end
    end
  end

  // R5: a four-station track can never be covered by anything longer.
  assert_full_span_uncovered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> !(alive_q[NC-1] == 1'b0 && $past(valid_c[NC-1]) && $past(upd_en)));

endmodule

// File: rtl/sp_best_select.sv
module sp_best_select
  import sp_trk_pkg::*;
#(
  parameter int N1   = 6,
  parameter int NS   = 3,
  parameter int QW   = 2,
  parameter int NOUT = 3,
  localparam int NB  = NS + 1,
  localparam int NC  = (N1 + 1) * NB * NB * NB,
  localparam int SW  = QW + 2,
  localparam int IW1 = $clog2(N1 + 1),
  localparam int IW  = $clog2(NS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_in,
  input  logic [NC-1:0]       alive,
  input  logic [SW-1:0]       qsum [NC],
  output logic                out_valid,
  output logic [NOUT-1:0]     cand_vld,
  output logic [NOUT*4-1:0]   cand_mask,
  output logic [NOUT*IW1-1:0] cand_s1,
  output logic [NOUT*IW-1:0]  cand_s2,
  output logic [NOUT*IW-1:0]  cand_s3,
  output logic [NOUT*IW-1:0]  cand_s4
);

  int                  sel_c [NOUT];
  logic [NOUT-1:0]     sel_ok;
  logic [NOUT-1:0]     nx_vld;
  logic [NOUT*4-1:0]   nx_mask;
  logic [NOUT*IW1-1:0] nx_s1;
  logic [NOUT*IW-1:0]  nx_s2, nx_s3, nx_s4;

  // Greedy rounds: best alive track that shares no stub with earlier picks.
  always_comb begin
    for (int r = 0; r < NOUT; r++) begin
      int bn;
      logic [SW-1:0] bs;
      sel_ok[r] = 1'b0;
      sel_c[r]  = 0;
      bn = 0;
      bs = '0;
      for (int c = 0; c < NC; c++) begin
        logic clash;
        clash = 1'b0;
        for (int p = 0; p < NOUT; p++)
          if (p < r && sel_ok[p])
            for (int s = 0; s < 4; s++)
              if (stub_at(c, s, NB) != 0 &&
                  stub_at(c, s, NB) == stub_at(sel_c[p], s, NB))
                clash = 1'b1;
        if (alive[c] && !clash) begin
          if (!sel_ok[r] || span_of(c, NB) > bn ||
              (span_of(c, NB) == bn && qsum[c] > bs)) begin
            sel_ok[r] = 1'b1;
            sel_c[r]  = c;
            bn = span_of(c, NB);
            bs = qsum[c];
          end
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NOUT; r++) begin
      nx_vld[r] = v_in && sel_ok[r];
      for (int s = 0; s < 4; s++)
        nx_mask[r*4+s] = nx_vld[r] && (stub_at(sel_c[r], s, NB) != 0);
      nx_s1[r*IW1 +: IW1] = nx_vld[r] ? IW1'(stub_at(sel_c[r], 0, NB)) : '0;
      nx_s2[r*IW  +: IW]  = nx_vld[r] ? IW'(stub_at(sel_c[r], 1, NB))  : '0;
      nx_s3[r*IW  +: IW]  = nx_vld[r] ? IW'(stub_at(sel_c[r], 2, NB))  : '0;
      nx_s4[r*IW  +: IW]  = nx_vld[r] ? IW'(stub_at(sel_c[r], 3, NB))  : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cand_vld  <= '0;
      cand_mask <= '0;
      cand_s1   <= '0;
      cand_s2   <= '0;
      cand_s3   <= '0;
      cand_s4   <= '0;
    end else begin
      out_valid <= v_in;
      cand_vld  <= nx_vld;
      cand_mask <= nx_mask;
      cand_s1   <= nx_s1;
      cand_s2   <= nx_s2;
      cand_s3   <= nx_s3;
      cand_s4   <= nx_s4;
    end
  end

  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (cand_vld == '0 && cand_mask == '0));

  generate
    for (genvar r = 0; r < NOUT; r++) begin : g_slot_chk
      assert_min_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld[r] |-> $countones(cand_mask[r*4 +: 4]) >= 2);
      assert_mask_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cand_mask[r*4 +: 4] == {cand_s4[r*IW +: IW] != '0, cand_s3[r*IW +: IW] != '0,
                                cand_s2[r*IW +: IW] != '0, cand_s1[r*IW1 +: IW1] != '0});
      if (r > 0) begin : g_order
        assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
          cand_vld[r] |-> cand_vld[r-1]);
      end
      for (genvar o = r + 1; o < NOUT; o++) begin : g_pair
        assert_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (cand_vld[r] && cand_vld[o]) |->
            ((cand_s1[r*IW1 +: IW1] == '0 || cand_s1[r*IW1 +: IW1] != cand_s1[o*IW1 +: IW1]) &&
             (cand_s2[r*IW +: IW] == '0 || cand_s2[r*IW +: IW] != cand_s2[o*IW +: IW]) &&
             (cand_s3[r*IW +: IW] == '0 || cand_s3[r*IW +: IW] != cand_s3[o*IW +: IW]) &&
             (cand_s4[r*IW +: IW] == '0 || cand_s4[r*IW +: IW] != cand_s4[o*IW +: IW])));
      end
    end
  endgenerate

endmodule

// File: rtl/sp_track_select.sv
module sp_track_select #(
  parameter int N1   = 6,
  parameter int NS   = 3,
  parameter int QW   = 2,
  parameter int NOUT = 3,
  localparam int W1  = N1 * NS * QW,
  localparam int W2  = NS * NS * QW,
  localparam int NB  = NS + 1,
  localparam int NC  = (N1 + 1) * NB * NB * NB,
  localparam int SW  = QW + 2,
  localparam int IW1 = $clog2(N1 + 1),
  localparam int IW  = $clog2(NS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W1-1:0]       lq12,
  input  logic [W1-1:0]       lq13,
  input  logic [W1-1:0]       lq14,
  input  logic [W2-1:0]       lq23,
  input  logic [W2-1:0]       lq24,
  input  logic [W2-1:0]       lq34,
  output logic                out_valid,
  output logic [NOUT-1:0]     cand_vld,
  output logic [NOUT*4-1:0]   cand_mask,
  output logic [NOUT*IW1-1:0] cand_s1,
  output logic [NOUT*IW-1:0]  cand_s2,
  output logic [NOUT*IW-1:0]  cand_s3,
  output logic [NOUT*IW-1:0]  cand_s4
);

  logic          rst_meta, rst_q;
  logic          v1, v2;
  logic [W1-1:0] lnk [6];
  logic [NC-1:0] alive;
  logic [SW-1:0] qsum [NC];
  logic [1:0]    since_rst;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  sp_link_capture #(.N1(N1), .NS(NS), .QW(QW)) u_cap (
    .clk(clk), .rst_n(rst_q), .in_valid(in_valid),
    .lq12(lq12), .lq13(lq13), .lq14(lq14),
    .lq23(lq23), .lq24(lq24), .lq34(lq34),
    .v_q(v1), .lnk_q(lnk)
  );

  sp_track_builder #(.N1(N1), .NS(NS), .QW(QW)) u_build (
    .clk(clk), .rst_n(rst_q), .v_in(v1), .lnk(lnk),
    .v_q(v2), .alive_q(alive), .qsum_q(qsum)
  );

  sp_best_select #(.N1(N1), .NS(NS), .QW(QW), .NOUT(NOUT)) u_sel (
    .clk(clk), .rst_n(rst_q), .v_in(v2), .alive(alive), .qsum(qsum),
    .out_valid(out_valid), .cand_vld(cand_vld), .cand_mask(cand_mask),
    .cand_s1(cand_s1), .cand_s2(cand_s2), .cand_s3(cand_s3), .cand_s4(cand_s4)
  );

  // Cycles since reset release, for the latency check window.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

endmodule

// File: tb/sp_track_select_bench.sv
module sp_track_select_bench;

  localparam int N1 = 6, NS = 3, QW = 2, NOUT = 3;
  localparam int W1 = N1 * NS * QW, W2 = NS * NS * QW;

  typedef struct {
    string       tag;
    logic [2:0]  v;
    logic [11:0] m;
    logic [8:0]  s1;
    logic [5:0]  s2, s3, s4;
  } exp_t;

  logic          clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W1-1:0] lq12 = '0, lq13 = '0, lq14 = '0;
  logic [W2-1:0] lq23 = '0, lq24 = '0, lq34 = '0;
  logic          out_valid;
  logic [2:0]    cand_vld;
  logic [11:0]   cand_mask;
  logic [8:0]    cand_s1;
  logic [5:0]    cand_s2, cand_s3, cand_s4;

  int   nchk = 0, nbad = 0;
  int   lq [6][7][4];
  exp_t sb_q [$];
  logic p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;
  logic mon_on = 1'b0;

  sp_track_select u_sp_track_select (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lq12(lq12), .lq13(lq13), .lq14(lq14), .lq23(lq23), .lq24(lq24), .lq34(lq34),
    .out_valid(out_valid), .cand_vld(cand_vld), .cand_mask(cand_mask),
    .cand_s1(cand_s1), .cand_s2(cand_s2), .cand_s3(cand_s3), .cand_s4(cand_s4)
  );

  always #5 clk = ~clk;

  function automatic int pno(int sa, int sb);
    case ({sa[1:0], sb[1:0]})
      4'b0001: return 0; 4'b0010: return 1; 4'b0011: return 2;
      4'b0110: return 3; 4'b0111: return 4; default: return 5;
    endcase
  endfunction

  task automatic clear_links();
    for (int p = 0; p < 6; p++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 4; b++) lq[p][a][b] = 0;
  endtask

  // stations numbered 1..4
  task automatic link(int sa, int sb, int a, int b, int q);
    lq[pno(sa - 1, sb - 1)][a][b] = q;
  endtask

  function automatic logic [W1-1:0] pack(int p);
    logic [W1-1:0] v;
    v = '0;
    for (int a = 1; a <= ((p < 3) ? N1 : NS); a++)
      for (int b = 1; b <= NS; b++)
        v[((a - 1) * NS + (b - 1)) * QW +: QW] = QW'(lq[p][a][b]);
    return v;
  endfunction

  task automatic model(input string tag, output exp_t e);
    int  st [448][4];
    int  ns [448], sm [448];
    bit  ok [448], live [448];
    int  pick [3];
    bit  got [3];
    for (int i1 = 0; i1 <= N1; i1++)
      for (int i2 = 0; i2 <= NS; i2++)
        for (int i3 = 0; i3 <= NS; i3++)
          for (int i4 = 0; i4 <= NS; i4++) begin
            int c, last, cnt, tot;
            bit good;
            c = ((i1 * 4 + i2) * 4 + i3) * 4 + i4;
            st[c][0] = i1; st[c][1] = i2; st[c][2] = i3; st[c][3] = i4;
            last = -1; cnt = 0; tot = 0; good = 1;
            for (int s = 0; s < 4; s++)
              if (st[c][s] != 0) begin
                if (last >= 0) begin
                  int q;
                  q = lq[pno(last, s)][st[c][last]][st[c][s]];
                  if (q == 0) good = 0;
                  tot += q;
                end
                last = s; cnt++;
              end
            ns[c] = cnt; sm[c] = tot; ok[c] = good && cnt >= 2;
          end
    for (int c = 0; c < 448; c++) begin
      live[c] = ok[c];
      if (ok[c])
        for (int d = 0; d < 448; d++)
          if (ok[d] && ns[d] >= 3 && ns[d] > ns[c]) begin
            bit sup;
            sup = 1;
            for (int s = 0; s < 4; s++)
              if (st[c][s] != 0 && st[d][s] != st[c][s]) sup = 0;
            if (sup) live[c] = 0;
          end
    end
    for (int r = 0; r < 3; r++) begin
      got[r] = 0; pick[r] = 0;
      for (int c = 0; c < 448; c++) begin
        bit clash;
        clash = 0;
        for (int p = 0; p < r; p++)
          if (got[p])
            for (int s = 0; s < 4; s++)
              if (st[c][s] != 0 && st[c][s] == st[pick[p]][s]) clash = 1;
        if (live[c] && !clash &&
            (!got[r] || ns[c] > ns[pick[r]] ||
             (ns[c] == ns[pick[r]] && sm[c] > sm[pick[r]]))) begin
          got[r] = 1; pick[r] = c;
        end
      end
    end
    e.tag = tag; e.v = '0; e.m = '0; e.s1 = '0; e.s2 = '0; e.s3 = '0; e.s4 = '0;
    for (int r = 0; r < 3; r++)
      if (got[r]) begin
        e.v[r] = 1'b1;
        for (int s = 0; s < 4; s++) e.m[r*4+s] = (st[pick[r]][s] != 0);
        e.s1[r*3 +: 3] = 3'(st[pick[r]][0]);
        e.s2[r*2 +: 2] = 2'(st[pick[r]][1]);
        e.s3[r*2 +: 2] = 2'(st[pick[r]][2]);
        e.s4[r*2 +: 2] = 2'(st[pick[r]][3]);
      end
  endtask

  // Driver: presents the current link table for one cycle, pushes expectation.
  task automatic drive_vec(input string tag);
    exp_t e;
    @(negedge clk);
    lq12 = pack(0); lq13 = pack(1); lq14 = pack(2);
    lq23 = pack(3)[W2-1:0]; lq24 = pack(4)[W2-1:0]; lq34 = pack(5)[W2-1:0];
    model(tag, e);
    sb_q.push_back(e);
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    p1 <= in_valid; p2 <= p1; p3 <= p2;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      nchk++;
      if (out_valid !== p3) begin
        nbad++;
        $display("FAIL R1 out_valid actual %b expected %b", out_valid, p3);
      end
      if (!out_valid) begin
        nchk++;
        if (cand_vld !== 3'b0 || cand_mask !== 12'b0) begin
          nbad++;
          $display("FAIL R11 idle fields actual vld=%b mask=%h expected 0/0", cand_vld, cand_mask);
        end
      end else if (sb_q.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R1 unexpected result actual out_valid=1 expected 0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        for (int r = 0; r < NOUT; r++) begin
          nchk++;
          if (cand_vld[r] !== e.v[r] || cand_mask[r*4 +: 4] !== e.m[r*4 +: 4] ||
              cand_s1[r*3 +: 3] !== e.s1[r*3 +: 3] || cand_s2[r*2 +: 2] !== e.s2[r*2 +: 2] ||
              cand_s3[r*2 +: 2] !== e.s3[r*2 +: 2] || cand_s4[r*2 +: 2] !== e.s4[r*2 +: 2]) begin
            nbad++;
            $display("FAIL %s slot %0d actual v=%b m=%h ids=%0d/%0d/%0d/%0d expected v=%b m=%h ids=%0d/%0d/%0d/%0d",
                     e.tag, r, cand_vld[r], cand_mask[r*4 +: 4], cand_s1[r*3 +: 3],
                     cand_s2[r*2 +: 2], cand_s3[r*2 +: 2], cand_s4[r*2 +: 2],
                     e.v[r], e.m[r*4 +: 4], e.s1[r*3 +: 3], e.s2[r*2 +: 2],
                     e.s3[r*2 +: 2], e.s4[r*2 +: 2]);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    nbad++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    clear_links();
    repeat (3) @(negedge clk);
    nchk++;   // R10: quiet during reset
    if (out_valid !== 1'b0 || cand_vld !== 3'b0) begin
      nbad++;
      $display("FAIL R10 in reset actual ov=%b vld=%b expected 0/0", out_valid, cand_vld);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nchk++;   // R10: quiet after release
    if (out_valid !== 1'b0 || cand_vld !== 3'b0 || cand_mask !== 12'b0) begin
      nbad++;
      $display("FAIL R10 after reset actual ov=%b vld=%b expected 0/0", out_valid, cand_vld);
    end
    mon_on = 1'b1;

    // R3 / R11: no links, no candidates
    drive_vec("R3_empty"); idle(4);
    // R2 / R3: single link at the highest indices
    clear_links(); link(1, 2, 6, 3, 1);
    drive_vec("R2_top_index"); idle(4);
    clear_links(); link(3, 4, 3, 1, 2);
    drive_vec("R3_pair34"); idle(4);
    // R4: full four-station chain
    clear_links(); link(1, 2, 2, 3, 1); link(2, 3, 3, 2, 1); link(3, 4, 2, 1, 1);
    drive_vec("R4_chain4"); idle(4);
    // R4: chain broken at station 2 (different shared stub)
    clear_links(); link(1, 2, 1, 1, 3); link(2, 3, 2, 1, 3);
    drive_vec("R4_broken"); idle(4);
    // R5: 2-3 track covered by a 2-3-4 track that itself loses a stub to 1-2-4
    clear_links(); link(1, 2, 1, 1, 3); link(2, 4, 1, 1, 3);
    link(2, 3, 2, 1, 1); link(3, 4, 1, 1, 1);
    drive_vec("R5_cancel"); idle(4);
    // R6: three stations with low quality beat two stations with high quality
    clear_links(); link(1, 3, 4, 2, 1); link(3, 4, 2, 3, 1); link(1, 2, 5, 2, 3);
    drive_vec("R6_span_first"); idle(4);
    clear_links(); link(1, 2, 3, 1, 1); link(1, 2, 4, 2, 3); link(1, 2, 5, 3, 2);
    drive_vec("R6_quality"); idle(4);
    // R7: equal rank, lower station-1 index first
    clear_links(); link(1, 2, 2, 1, 2); link(1, 2, 1, 2, 2);
    drive_vec("R7_tie_s1"); idle(4);
    clear_links(); link(2, 3, 2, 1, 2); link(2, 3, 1, 2, 2);
    drive_vec("R7_tie_s2"); idle(4);
    // R8: shared station-1 stub
    clear_links(); link(1, 2, 1, 1, 3); link(1, 3, 1, 1, 3); link(1, 4, 2, 2, 1);
    drive_vec("R8_shared"); idle(4);
    // R9: more than three disjoint tracks
    clear_links();
    for (int a = 1; a <= 4; a++) link(1, 4, a, ((a - 1) % 3) + 1, a % 4 == 0 ? 3 : a);
    link(2, 3, 3, 3, 3);
    drive_vec("R9_overflow"); idle(4);

    // R1: back-to-back random sectors
    for (int v = 0; v < 48; v++) begin
      clear_links();
      for (int p = 0; p < 6; p++)
        for (int a = 1; a <= ((p < 3) ? N1 : NS); a++)
          for (int b = 1; b <= NS; b++)
            if ($urandom_range(0, 4) == 0) lq[p][a][b] = $urandom_range(1, 3);
      drive_vec("R1_stream");
      if (v % 8 == 7) idle(2);
    end
    idle(8);

    nchk++;
    if (sb_q.size() != 0) begin
      nbad++;
      $display("FAIL R1 pending results actual %0d expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule